// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a set of interrupt lines (32 by default) and presents one active-low request line, `irq_n`, to a processor. Each source has a control register. The register selects how the input is sensed: low level, high level, falling edge or rising edge. It also holds a 3-bit priority. A global enable set is changed through two command addresses. Writing 1 to a bit of the enable command turns that source on. Writing 1 to a bit of the disable command turns it off. Bits written 0 leave the set unchanged.

To take an interrupt, the processor reads the acknowledge address. That read returns the number of the winning source multiplied by four, and it moves that source into service, so `irq_n` deasserts. While a source is in service, only a source of strictly higher priority can raise `irq_n` again. A write of any value to the end-of-service address releases the service state. A separate source-number address reports the source in service and has no side effects.

Top module: `pic_vectored`

## Requirements
- R1: After reset, `irq_n` is 1, every source is disabled (mask status reads 0), every control register reads 0, and the acknowledge and source-number addresses read 0.
- R2: A control register at byte address 4*n holds the sense type in bits 7:6 (0 low level, 1 high level, 2 falling edge, 3 rising edge) and the priority in bits 2:0. All its other bits read 0.
- R3: A write to 0x8C sets the enable of every source whose data bit is 1. A write to 0x90 clears the enable of every source whose data bit is 1. Bits written 0 are unchanged in both cases. Address 0x88 reads the enable set.
- R4: A level-sensed source is pending for as long as its input is at the selected level, measured after a two-flop synchroniser.
- R5: An edge-sensed source latches a pending flag on the selected edge of its synchronised input. The flag holds after the input returns and clears only when that source is acknowledged.
- R6: Among sources that are both pending and enabled, the higher priority value wins. A tie goes to the lower source number. Disabled sources never win.
- R7: When no source is in service, `irq_n` is 0 exactly when some enabled source is pending.
- R8: A read of 0x80 with a winner present returns the winner number times 4 and puts that source in service. `irq_n` is 1 in the following cycle unless a strictly higher source is pending.
- R9: While a source is in service, `irq_n` goes to 0 only for a pending enabled source of strictly higher priority. A write of any value to 0x94 ends service.
- R10: A read of 0x84 returns the number of the source last acknowledged and changes no state.
- R11: A read of 0x80 with no enabled source pending returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NSRC | Asynchronous interrupt source inputs |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the read strobe |
| irq_n | output | 1 | Active-low interrupt request to the processor |

## Verification
The assertions watch several rules on every clock cycle. A low `irq_n` must always be backed by an enabled pending source. An acknowledge with a winner must capture that winner as the source in service. An end-of-service write, an empty acknowledge and a source-number read must each have their exact effect on the service state. A disable command must clear every enable bit it names. Some behaviour is shown only by the bench's scenarios. These are the priority and tie order across several input patterns, the way each of the four sense types turns an input into a pending source, the strictly-higher preemption rule, and the values returned on the bus.

// File: rtl/pic_pkg.sv
// Shared types and register offsets for the vectored interrupt controller.
// Assumes a byte-addressed bus with 32-bit words.
package pic_pkg;
    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_FALL = 2'd2,
        TRIG_RISE = 2'd3
    } trig_e;

    localparam int unsigned OFS_ACK    = 32'h80;
    localparam int unsigned OFS_SRCNUM = 32'h84;
    localparam int unsigned OFS_MASK   = 32'h88;
    localparam int unsigned OFS_EN     = 32'h8C;
    localparam int unsigned OFS_DIS    = 32'h90;
    localparam int unsigned OFS_EOS    = 32'h94;
endpackage

// File: rtl/pic_src_detect.sv
// Per-source sensing: synchronises one asynchronous input and turns it into a
// pending indication according to the selected sense type.
// Assumes ack_hit pulses for one cycle when this source is acknowledged.
module pic_src_detect
    import pic_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  src_in,
    input  trig_e trig,
    input  logic  ack_hit,
    output logic  pending
);
    logic s1_q, s2_q, s3_q, edge_q;
    logic rise, fall;

    // Two-flop synchroniser plus one delay stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= src_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign rise = s2_q & ~s3_q;
    assign fall = ~s2_q & s3_q;

    // Edge latch: set on the selected edge, cleared on acknowledge or in level mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= 1'b0;
        end else if ((trig == TRIG_RISE && rise) || (trig == TRIG_FALL && fall)) begin
            edge_q <= 1'b1;
        end else if (ack_hit || !trig[1]) begin
            edge_q <= 1'b0;
        end
    end

    // Select the pending source by sense type
    always_comb begin
        case (trig)
            TRIG_LOW:  pending = ~s2_q;
            TRIG_HIGH: pending = s2_q;
            default:   pending = edge_q;
        endcase
    end
endmodule

// File: rtl/pic_arbiter.sv
// Combinational priority selection: the highest priority among requesting
// sources wins, and ties go to the lowest index because the compare is strict.
// Assumes the priorities are packed PRI_W bits per source, source 0 lowest.
module pic_arbiter #(
    parameter int NSRC  = 32,
    parameter int PRI_W = 3,
    parameter int ID_W  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]       req,
    input  logic [NSRC*PRI_W-1:0] pri_flat,
    output logic                  win_valid,
    output logic [ID_W-1:0]       win_id,
    output logic [PRI_W-1:0]      win_pri
);
    // Linear scan keeps the first source that has the strictly best priority
    always_comb begin
        logic             found;
        logic [ID_W-1:0]  best_id;
        logic [PRI_W-1:0] best_pri;
        found    = 1'b0;
        best_id  = '0;
        best_pri = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req[i] && (!found || pri_flat[i*PRI_W +: PRI_W] > best_pri)) begin
                found    = 1'b1;
                best_id  = ID_W'(i);
                best_pri = pri_flat[i*PRI_W +: PRI_W];
            end
        end
        win_valid = found;
        win_id    = best_id;
        win_pri   = best_pri;
    end
endmodule

// File: rtl/pic_vectored.sv
// Top of the vectored priority interrupt controller: register file, enable set,
// one-level service state and the active-low request output.
// Assumes one bus access per cycle, with read data taken in the strobe cycle.
module pic_vectored
    import pic_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int PRI_W  = 3,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_n
);
    localparam int ID_W = $clog2(NSRC);

    trig_e              trig_q [NSRC];
    logic [PRI_W-1:0]   pri_q  [NSRC];
    logic [NSRC*PRI_W-1:0] pri_flat;
    logic [NSRC-1:0]    en_q, pend, req;
    logic               in_svc_q;
    logic [ID_W-1:0]    svc_id_q;
    logic [PRI_W-1:0]   svc_pri_q;
    logic               win_valid;
    logic [ID_W-1:0]    win_id;
    logic [PRI_W-1:0]   win_pri;

    logic acc_rd, acc_wr, ctrl_hit;
    logic ack_rd, num_rd, en_wr, dis_wr, eos_wr;
    logic [ID_W-1:0] ctrl_idx;

    assign acc_rd   = bus_en && !bus_wr;
    assign acc_wr   = bus_en && bus_wr;
    assign ctrl_hit = int'(bus_addr) < NSRC * 4;
    assign ctrl_idx = bus_addr[ID_W+1:2];
    assign ack_rd   = acc_rd && int'(bus_addr) == OFS_ACK;
    assign num_rd   = acc_rd && int'(bus_addr) == OFS_SRCNUM;
    assign en_wr    = acc_wr && int'(bus_addr) == OFS_EN;
    assign dis_wr   = acc_wr && int'(bus_addr) == OFS_DIS;
    assign eos_wr   = acc_wr && int'(bus_addr) == OFS_EOS;

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            // Per-source control register write
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    trig_q[g] <= TRIG_LOW;
                    pri_q[g]  <= '0;
                end else if (acc_wr && ctrl_hit && ctrl_idx == ID_W'(g)) begin
                    trig_q[g] <= trig_e'(bus_wdata[7:6]);
                    pri_q[g]  <= bus_wdata[PRI_W-1:0];
                end
            end

            assign pri_flat[g*PRI_W +: PRI_W] = pri_q[g];

            pic_src_detect u_det (
                .clk     (clk),
                .rst_n   (rst_n),
                .src_in  (src_i[g]),
                .trig    (trig_q[g]),
                .ack_hit (ack_rd && win_valid && win_id == ID_W'(g)),
                .pending (pend[g])
            );
        end
    endgenerate

    assign req = pend & en_q;

    pic_arbiter #(.NSRC(NSRC), .PRI_W(PRI_W), .ID_W(ID_W)) u_arb (
        .req       (req),
        .pri_flat  (pri_flat),
        .win_valid (win_valid),
        .win_id    (win_id),
        .win_pri   (win_pri)
    );

    // Enable set: write-1-to-set and write-1-to-clear commands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_wr) begin
            en_q <= en_q | bus_wdata[NSRC-1:0];
        end else if (dis_wr) begin
            en_q <= en_q & ~bus_wdata[NSRC-1:0];
        end
    end

    // Service state: captured on acknowledge, released on end of service
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_svc_q  <= 1'b0;
            svc_id_q  <= '0;
            svc_pri_q <= '0;
        end else if (ack_rd && win_valid) begin
            in_svc_q  <= 1'b1;
            svc_id_q  <= win_id;
            svc_pri_q <= win_pri;
        end else if (eos_wr) begin
            in_svc_q  <= 1'b0;
        end
    end

    // Request output: idle controller or strictly higher preemption
    assign irq_n = !(win_valid && (!in_svc_q || win_pri > svc_pri_q));

    // Read data multiplexer
    always_comb begin
        bus_rdata = '0;
        if (acc_rd) begin
            if (ctrl_hit) begin
                bus_rdata[7:6]       = trig_q[ctrl_idx];
                bus_rdata[PRI_W-1:0] = pri_q[ctrl_idx];
            end else begin
                case (int'(bus_addr))
                    OFS_ACK:    if (win_valid) bus_rdata = DATA_W'(win_id) << 2;
                    OFS_SRCNUM: bus_rdata = DATA_W'(svc_id_q);
                    OFS_MASK:   bus_rdata[NSRC-1:0] = en_q;
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/pic_vectored_chk.sv
// Checker for pic_vectored, bound into every instance. It decodes the bus on
// its own and relates commands to the service and enable state.
module pic_vectored_chk
    import pic_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int ID_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq_n,
    input logic [NSRC-1:0]   en_q,
    input logic [NSRC-1:0]   req,
    input logic              win_valid,
    input logic [ID_W-1:0]   win_id,
    input logic              in_svc_q,
    input logic [ID_W-1:0]   svc_id_q
);
    logic c_ack, c_num, c_dis, c_eos;
    assign c_ack = bus_en && !bus_wr && int'(bus_addr) == OFS_ACK;
    assign c_num = bus_en && !bus_wr && int'(bus_addr) == OFS_SRCNUM;
    assign c_dis = bus_en && bus_wr && int'(bus_addr) == OFS_DIS;
    assign c_eos = bus_en && bus_wr && int'(bus_addr) == OFS_EOS;

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (irq_n && en_q == '0));

    assert_irq_backed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (req != '0));

    assert_ack_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ack && win_valid) |=> (in_svc_q && svc_id_q == $past(win_id)));

    assert_eos_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        c_eos |=> !in_svc_q);

    assert_disable_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        c_dis |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == '0));

    assert_srcnum_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        c_num |=> (in_svc_q == $past(in_svc_q) && svc_id_q == $past(svc_id_q)));

    assert_empty_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ack && !win_valid) |=> (in_svc_q == $past(in_svc_q)));
endmodule

bind pic_vectored pic_vectored_chk #(
    .NSRC(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_n     (irq_n),
    .en_q      (en_q),
    .req       (req),
    .win_valid (win_valid),
    .win_id    (win_id),
    .in_svc_q  (in_svc_q),
    .svc_id_q  (svc_id_q)
);

// File: tb/tb_pic_vectored.sv
// Bench for pic_vectored: a vector table for arbitration, then directed tests.
module tb_pic_vectored;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_n;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pic_vectored dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] en;
        logic        irqn;
        logic [31:0] rd;
    } vec_t;

    // Priority of source i is (3*i) mod 8, all sources high-level sensed
    localparam vec_t VECS [7] = '{
        '{32'h0000_0006, 32'hFFFF_FFFF, 1'b0, 32'd8},
        '{32'h0000_0022, 32'hFFFF_FFFF, 1'b0, 32'd20},
        '{32'h0000_2020, 32'hFFFF_FFFF, 1'b0, 32'd20},
        '{32'h0000_2020, 32'hFFFF_FFDF, 1'b0, 32'd52},
        '{32'h0000_0000, 32'hFFFF_FFFF, 1'b1, 32'd0},
        '{32'h8000_0001, 32'hFFFF_FFFF, 1'b0, 32'd124},
        '{32'h0000_0101, 32'hFFFF_FFFF, 1'b0, 32'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic set_mask(input logic [31:0] m);
        wr(8'h90, 32'hFFFF_FFFF);
        wr(8'h8C, m);
    endtask

    // Watchdog: an expired run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        check("R1 irq_n", {31'b0, irq_n}, 32'd1);
        rd(8'h88, d); check("R1 mask", d, 32'd0);
        rd(8'h14, d); check("R1 ctrl5", d, 32'd0);
        rd(8'h80, d); check("R1 ack", d, 32'd0);
        rd(8'h84, d); check("R1 srcnum", d, 32'd0);

        // R2: field placement, unused bits read 0
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h28, d); check("R2 ctrl10", d, 32'h0000_00C7);

        // R3: write-1 set and clear, zero bits unchanged
        wr(8'h8C, 32'h3);
        wr(8'h90, 32'h1);
        rd(8'h88, d); check("R3 mask", d, 32'h2);
        wr(8'h8C, 32'h10);
        rd(8'h88, d); check("R3 mask set", d, 32'h12);

        for (int i = 0; i < 32; i++) wr(8'(i * 4), 32'h40 | ((i * 3) % 8));

        // R6 R7 R8: vector table
        for (int v = 0; v < 7; v++) begin
            set_mask(VECS[v].en);
            src_i = VECS[v].src;
            idle(4);
            check("R7 irq_n", {31'b0, irq_n}, {31'b0, VECS[v].irqn});
            rd(8'h80, d); check("R6 R8 ack value", d, VECS[v].rd);
            if (!VECS[v].irqn) check("R8 irq_n after ack", {31'b0, irq_n}, 32'd1);
            wr(8'h94, 32'h0);
        end

        // R4: low-level sensing
        src_i = '0;
        wr(8'h0C, 32'h02);
        set_mask(32'h8);
        idle(4);
        check("R4 low pending", {31'b0, irq_n}, 32'd0);
        rd(8'h80, d); check("R4 ack", d, 32'd12);
        wr(8'h94, 32'h0);
        src_i[3] = 1'b1;
        idle(4);
        check("R4 high not pending", {31'b0, irq_n}, 32'd1);

        // R5: rising edge latch and clear on acknowledge
        wr(8'h10, 32'hC4);
        set_mask(32'h10);
        src_i[4] = 1'b1; idle(3); src_i[4] = 1'b0;
        idle(4);
        check("R5 rise latched", {31'b0, irq_n}, 32'd0);
        rd(8'h80, d); check("R5 ack", d, 32'd16);
        rd(8'h84, d); check("R10 srcnum", d, 32'd4);
        wr(8'h94, 32'h0);
        idle(2);
        check("R5 flag cleared", {31'b0, irq_n}, 32'd1);

        // R5: falling edge
        src_i[6] = 1'b1; idle(4);
        wr(8'h18, 32'h82);
        set_mask(32'h40);
        idle(4);
        check("R5 no fall yet", {31'b0, irq_n}, 32'd1);
        src_i[6] = 1'b0; idle(4);
        check("R5 fall latched", {31'b0, irq_n}, 32'd0);
        rd(8'h80, d); check("R5 fall ack", d, 32'd24);
        wr(8'h94, 32'h0);

        // R9: preemption only by strictly higher priority
        src_i = 32'h2;
        set_mask(32'h206);
        idle(4);
        rd(8'h80, d); check("R9 first ack", d, 32'd4);
        src_i[9] = 1'b1; idle(4);
        check("R9 equal no preempt", {31'b0, irq_n}, 32'd1);
        rd(8'h84, d); check("R10 srcnum", d, 32'd1);
        check("R10 no side effect", {31'b0, irq_n}, 32'd1);
        src_i[2] = 1'b1; idle(4);
        check("R9 higher preempts", {31'b0, irq_n}, 32'd0);
        rd(8'h80, d); check("R9 second ack", d, 32'd8);
        wr(8'h94, 32'h0);
        check("R9 eos releases", {31'b0, irq_n}, 32'd0);

        // R11: empty acknowledge
        src_i = '0;
        idle(4);
        rd(8'h80, d); check("R11 empty ack", d, 32'd0);
        rd(8'h84, d); check("R11 srcnum kept", d, 32'd2);
        check("R11 irq_n", {31'b0, irq_n}, 32'd1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule